// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a configuration fabric. It exposes two 32-bit I/O ports: an address port at 0xCF8 and a data port at 0xCFC. Software writes a packed selector word to the address port. The word names a bus, a device, a function and a dword-aligned register offset, plus an enable flag in bit 31. Software then reads or writes the data port. Every data-port access becomes one configuration request on a simple request/acknowledge interface toward the bus. This lets a single data window reach any register of any function on any bus.

The block holds the host until the bus side acknowledges the request. If no acknowledge arrives, an internal timeout ends the request. Byte and word accesses to the data-port window produce byte enables and lane-aligned data. The block marks each request for the local bus (type 0, bus field zero) or for a bus behind a bridge (type 1).

Top module: `cfg_port_bridge`

## Requirements
- R1: A dword write (io_size_i of 2 or 3) to I/O address 0xCF8 latches the selector word. A dword read there returns it, with bits 30:24 and 1:0 reading as zero. After reset the readback is zero.
- R2: A request carries bus = selector bits 23:16 on cfg_bus_o and devfn = selector bits 15:8 on cfg_devfn_o (device in 15:11, function in 10:8). It carries the register offset on cfg_reg_o: selector bits 7:2, with bits 1:0 zero.
- R3: While selector bit 31 is 0, a data-port read returns 0xFFFFFFFF and a data-port write is dropped. Neither issues a request.
- R4: io_size_i encodes 0 = byte, 1 = word, 2 or 3 = dword, and the data-port lane offset is io_addr_i[1:0]. A byte access sets cfg_be_o = 0001 shifted left by the offset. A word access sets 0011 shifted left by the offset, truncated to 4 bits. A dword access sets 1111. Write data moves up to the enabled lanes. Read data moves down by the offset, and lanes beyond the access size return zero.
- R5: cfg_type1_o is 0 when the bus field is 0 and 1 otherwise.
- R6: io_ready_o is a one-cycle pulse that completes each host access. For a forwarded access it comes only after cfg_ack_i, and io_rdata_o then carries the acknowledged data.
- R7: If cfg_ack_i does not come within TMO_CYCLES cycles of the request, the request is withdrawn and the access completes. A read then returns 0xFFFFFFFF.
- R8: Accesses to any other I/O address, and non-dword accesses to the address port, issue no request, leave the selector unchanged and return 0xFFFFFFFF on a read.
- R9: While a request waits for its acknowledge, its byte enables, write data and direction stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_req_i | input | 1 | Host access pending, held until io_ready_o |
| io_we_i | input | 1 | Host access is a write |
| io_addr_i | input | IO_AW | Host I/O byte address |
| io_size_i | input | 2 | Access size: 0 byte, 1 word, 2/3 dword |
| io_wdata_i | input | 32 | Host write data, low-aligned |
| io_ready_o | output | 1 | Access complete pulse |
| io_rdata_o | output | 32 | Host read data, valid with io_ready_o |
| cfg_req_o | output | 1 | Configuration request pending |
| cfg_we_o | output | 1 | Request is a write |
| cfg_type1_o | output | 1 | Request targets a bus behind a bridge |
| cfg_bus_o | output | 8 | Target bus number |
| cfg_devfn_o | output | 8 | Device and function |
| cfg_reg_o | output | 8 | Dword-aligned register offset |
| cfg_be_o | output | 4 | Byte enables |
| cfg_wdata_o | output | 32 | Lane-aligned write data |
| cfg_ack_i | input | 1 | Completion from the bus side |
| cfg_rdata_i | input | 32 | Completion read data |

## Verification
The assertions assume two things about the host and the bus side. The host holds io_we_i, io_addr_i, io_size_i and io_wdata_i steady from raising io_req_i until it sees io_ready_o. The bus side raises cfg_ack_i for one cycle, and only while cfg_req_o is high. The bench's host task changes inputs only at falling edges and drops the request on the same edge where it samples the completion. The bench's responder acknowledges only a pending request, after a programmable delay shorter than the timeout, and is switched off entirely for the timeout scenarios.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

  localparam int unsigned CFG_DW  = 32;
  localparam int unsigned LANES   = CFG_DW / 8;
  localparam int unsigned OFF_W   = $clog2(LANES);

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_BUSY = 2'd1,
    XS_DONE = 2'd2
  } xact_st_e;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
  } cfg_sel_t;

  function automatic cfg_sel_t unpack_sel(input logic [CFG_DW-1:0] w);
    cfg_sel_t s;
    s.en  = w[31];
    s.bus = w[23:16];
    s.dev = w[15:11];
    s.fn  = w[10:8];
    s.dw  = w[7:2];
    return s;
  endfunction

  function automatic logic [CFG_DW-1:0] pack_sel(input cfg_sel_t s);
    return {s.en, 7'd0, s.bus, s.dev, s.fn, s.dw, 2'b00};
  endfunction

  function automatic logic size_is_dword(input logic [1:0] sz);
    return sz[1];
  endfunction

endpackage

// File: rtl/cfg_sel_reg.sv
module cfg_sel_reg
  import cfg_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output cfg_sel_t          sel_o,
  output logic [CFG_DW-1:0] rdback_o
);

  cfg_sel_t sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= '0;
    else if (wr_i) sel_q <= unpack_sel(wdata_i);
  end

  assign sel_o    = sel_q;
  assign rdback_o = pack_sel(sel_q);

  // reserved selector bits are discarded
  logic unused_rsvd;
  assign unused_rsvd = ^{wdata_i[30:24], wdata_i[1:0]};

  // R1
  sel_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rdback_o[23:2] == $past(wdata_i[23:2])) && (rdback_o[31] == $past(wdata_i[31])));

endmodule

// File: rtl/cfg_lane_enc.sv
module cfg_lane_enc
  import cfg_bridge_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [CFG_DW-1:0] host_wdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [CFG_DW-1:0] bus_wdata_o
);

  localparam logic [LANES-1:0] ONE_LANE = LANES'(1);
  localparam logic [LANES-1:0] TWO_LANE = LANES'(3);

  logic [OFF_W-1:0] sh;

  always_comb begin
    sh = size_is_dword(size_i) ? '0 : off_i;
    unique case (size_i)
      2'd0:    be_o = ONE_LANE << sh;
      2'd1:    be_o = TWO_LANE << sh;
      default: be_o = '1;
    endcase
    bus_wdata_o = host_wdata_i << {sh, 3'b000};
  end

endmodule

// File: rtl/cfg_lane_dec.sv
module cfg_lane_dec
  import cfg_bridge_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [CFG_DW-1:0] bus_rdata_i,
  output logic [CFG_DW-1:0] host_rdata_o
);

  logic [OFF_W-1:0]  sh;
  logic [CFG_DW-1:0] shifted;

  assign sh      = size_is_dword(size_i) ? '0 : off_i;
  assign shifted = bus_rdata_i >> {sh, 3'b000};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic keep;
    assign keep = size_is_dword(size_i) || (l == 0) || ((size_i == 2'd1) && (l == 1));
    assign host_rdata_o[8*l +: 8] = keep ? shifted[8*l +: 8] : 8'h00;
  end

endmodule

// File: rtl/cfg_xact_fsm.sv
module cfg_xact_fsm
  import cfg_bridge_pkg::*;
#(
  parameter int unsigned TMO_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_bus_i,
  input  logic              start_local_i,
  input  logic [CFG_DW-1:0] local_rdata_i,
  input  logic              bus_ack_i,
  input  logic [CFG_DW-1:0] bus_rdata_i,
  output logic              idle_o,
  output logic              bus_req_o,
  output logic              ready_o,
  output logic [CFG_DW-1:0] rdata_o
);

  localparam int unsigned     CNT_W    = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

  xact_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              req_q;
  logic [CFG_DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= XS_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        XS_IDLE: begin
          cnt_q <= '0;
          if (start_bus_i) begin
            st_q  <= XS_BUSY;
            req_q <= 1'b1;
          end else if (start_local_i) begin
            st_q    <= XS_DONE;
            rdata_q <= local_rdata_i;
          end
        end
        XS_BUSY: begin
          if (bus_ack_i) begin
            st_q    <= XS_DONE;
            req_q   <= 1'b0;
            rdata_q <= bus_rdata_i;
          end else if (cnt_q == CNT_LAST) begin
            st_q    <= XS_DONE;
            req_q   <= 1'b0;
            rdata_q <= '1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  assign idle_o    = (st_q == XS_IDLE);
  assign bus_req_o = req_q;
  assign ready_o   = (st_q == XS_DONE);
  assign rdata_o   = rdata_q;

  // R6
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  // R6
  req_ends_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |-> ready_o);

  // R7
  tmo_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bus_req_o) && !$past(bus_ack_i)) |-> (rdata_o == '1));

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int unsigned IO_AW      = 16,
  parameter int unsigned ADDR_PORT  = 32'h0CF8,
  parameter int unsigned DATA_PORT  = 32'h0CFC,
  parameter int unsigned TMO_CYCLES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_req_i,
  input  logic             io_we_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic [1:0]       io_size_i,
  input  logic [31:0]      io_wdata_i,
  output logic             io_ready_o,
  output logic [31:0]      io_rdata_o,
  output logic             cfg_req_o,
  output logic             cfg_we_o,
  output logic             cfg_type1_o,
  output logic [7:0]       cfg_bus_o,
  output logic [7:0]       cfg_devfn_o,
  output logic [7:0]       cfg_reg_o,
  output logic [3:0]       cfg_be_o,
  output logic [31:0]      cfg_wdata_o,
  input  logic             cfg_ack_i,
  input  logic [31:0]      cfg_rdata_i
);

  localparam logic [IO_AW-1:0] ADDR_P = ADDR_PORT[IO_AW-1:0];
  localparam logic [IO_AW-1:0] DATA_P = DATA_PORT[IO_AW-1:0];

  cfg_sel_t          sel;
  logic [CFG_DW-1:0] sel_rdback;
  logic              idle;
  logic              hit_addr, hit_data;
  logic              start_bus, start_local, sel_wr;
  logic [CFG_DW-1:0] local_rdata;
  logic [LANES-1:0]  be_d;
  logic [CFG_DW-1:0] wdata_d;
  logic [CFG_DW-1:0] rdata_dec;

  logic              we_q;
  logic [LANES-1:0]  be_q;
  logic [CFG_DW-1:0] wdata_q;
  logic [1:0]        size_q;
  logic [OFF_W-1:0]  off_q;

  // port decode
  assign hit_addr = (io_addr_i[IO_AW-1:2] == ADDR_P[IO_AW-1:2]) && size_is_dword(io_size_i);
  assign hit_data = (io_addr_i[IO_AW-1:2] == DATA_P[IO_AW-1:2]);

  assign start_bus   = io_req_i && idle && hit_data && sel.en;
  assign start_local = io_req_i && idle && !start_bus;
  assign sel_wr      = io_req_i && idle && hit_addr && io_we_i;
  assign local_rdata = (hit_addr && !io_we_i) ? sel_rdback : '1;

  cfg_sel_reg u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (sel_wr),
    .wdata_i  (io_wdata_i),
    .sel_o    (sel),
    .rdback_o (sel_rdback)
  );

  cfg_lane_enc u_enc (
    .size_i       (io_size_i),
    .off_i        (io_addr_i[OFF_W-1:0]),
    .host_wdata_i (io_wdata_i),
    .be_o         (be_d),
    .bus_wdata_o  (wdata_d)
  );

  // capture request attributes at issue
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      off_q   <= '0;
    end else if (start_bus) begin
      we_q    <= io_we_i;
      be_q    <= be_d;
      wdata_q <= wdata_d;
      size_q  <= io_size_i;
      off_q   <= io_addr_i[OFF_W-1:0];
    end
  end

  cfg_lane_dec u_dec (
    .size_i       (size_q),
    .off_i        (off_q),
    .bus_rdata_i  (cfg_rdata_i),
    .host_rdata_o (rdata_dec)
  );

  cfg_xact_fsm #(.TMO_CYCLES(TMO_CYCLES)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_bus_i   (start_bus),
    .start_local_i (start_local),
    .local_rdata_i (local_rdata),
    .bus_ack_i     (cfg_ack_i),
    .bus_rdata_i   (rdata_dec),
    .idle_o        (idle),
    .bus_req_o     (cfg_req_o),
    .ready_o       (io_ready_o),
    .rdata_o       (io_rdata_o)
  );

  assign cfg_we_o    = we_q;
  assign cfg_be_o    = be_q;
  assign cfg_wdata_o = wdata_q;
  assign cfg_bus_o   = sel.bus;
  assign cfg_devfn_o = {sel.dev, sel.fn};
  assign cfg_reg_o   = {sel.dw, 2'b00};
  assign cfg_type1_o = (sel.bus != 8'd0);

  // R3
  req_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_req_o) |-> sel_rdback[31]);

  // R2
  reg_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> (cfg_reg_o[1:0] == 2'b00));

  // R4
  be_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> (cfg_be_o != 4'b0000));

  // R9
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && $past(cfg_req_o) && !$past(cfg_ack_i))
      |-> ($stable(cfg_be_o) && $stable(cfg_wdata_o) && $stable(cfg_we_o) && $stable(cfg_bus_o)));

endmodule

// File: tb/tb_cfg_port_bridge.sv
module tb_cfg_port_bridge;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        io_req_i = 1'b0;
  logic        io_we_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [1:0]  io_size_i = '0;
  logic [31:0] io_wdata_i = '0;
  logic        io_ready_o;
  logic [31:0] io_rdata_o;
  logic        cfg_req_o, cfg_we_o, cfg_type1_o;
  logic [7:0]  cfg_bus_o, cfg_devfn_o, cfg_reg_o;
  logic [3:0]  cfg_be_o;
  logic [31:0] cfg_wdata_o;
  logic        cfg_ack_i = 1'b0;
  logic [31:0] cfg_rdata_i = '0;

  always #5 clk_i = ~clk_i;

  cfg_port_bridge dut (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // responder controls
  bit          resp_on  = 1'b1;
  int          resp_lat = 0;
  logic [31:0] resp_data = 32'hA1B2C3D4;
  int          wait_cnt = 0;

  // request capture
  int          req_cnt = 0;
  bit          req_prev = 0;
  logic        cap_we, cap_t1;
  logic [7:0]  cap_bus, cap_devfn, cap_reg;
  logic [3:0]  cap_be;
  logic [31:0] cap_wdata;

  initial forever begin
    @(negedge clk_i);
    if (cfg_ack_i) begin
      cfg_ack_i = 1'b0;
      wait_cnt  = 0;
    end else if (cfg_req_o && resp_on) begin
      if (wait_cnt >= resp_lat) begin
        cfg_ack_i   = 1'b1;
        cfg_rdata_i = resp_data;
      end else wait_cnt++;
    end else wait_cnt = 0;
  end

  initial forever begin
    @(negedge clk_i);
    if (cfg_req_o && !req_prev) begin
      req_cnt++;
      cap_we = cfg_we_o; cap_t1 = cfg_type1_o; cap_bus = cfg_bus_o;
      cap_devfn = cfg_devfn_o; cap_reg = cfg_reg_o; cap_be = cfg_be_o;
      cap_wdata = cfg_wdata_o;
    end
    req_prev = cfg_req_o;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic io_xfer(input logic we, input logic [15:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk_i);
    io_req_i = 1'b1; io_we_i = we; io_addr_i = a; io_size_i = sz; io_wdata_i = wd;
    cyc = 0;
    do begin
      @(negedge clk_i);
      cyc++;
    end while (!io_ready_o && cyc < 1000);
    rd = io_rdata_o;
    io_req_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R6 ready after reset", {31'd0, io_ready_o}, 32'd0);
    check("R6 req after reset", {31'd0, cfg_req_o}, 32'd0);
  endtask

  task automatic t_sel_readback();
    logic [31:0] rd; int cyc;
    io_xfer(0, 16'h0CF8, 2'd2, 0, rd, cyc);
    check("R1 readback after reset", rd, 32'h0);
    io_xfer(1, 16'h0CF8, 2'd2, 32'hFFFF_FFFF, rd, cyc);
    io_xfer(0, 16'h0CF8, 2'd2, 0, rd, cyc);
    check("R1 reserved bits zero", rd, 32'h80FF_FFFC);
  endtask

  task automatic t_disabled();
    logic [31:0] rd; int cyc; int n0;
    io_xfer(1, 16'h0CF8, 2'd2, 32'h0005_1A0C, rd, cyc);
    n0 = req_cnt;
    io_xfer(0, 16'h0CFC, 2'd2, 0, rd, cyc);
    check("R3 disabled read ones", rd, 32'hFFFF_FFFF);
    io_xfer(1, 16'h0CFC, 2'd2, 32'h1234_5678, rd, cyc);
    check("R3 disabled no request", req_cnt, n0);
  endtask

  task automatic t_dword_read_bus0();
    logic [31:0] rd; int cyc;
    resp_lat = 3;
    io_xfer(1, 16'h0CF8, 2'd2, 32'h8000_1A0C, rd, cyc);
    io_xfer(0, 16'h0CFC, 2'd2, 0, rd, cyc);
    check("R6 read data", rd, 32'hA1B2_C3D4);
    check("R2 bus", cap_bus, 8'h00);
    check("R2 devfn", cap_devfn, 8'h1A);
    check("R2 reg", cap_reg, 8'h0C);
    check("R5 type0", cap_t1, 1'b0);
    check("R4 dword be", cap_be, 4'hF);
  endtask

  task automatic t_dword_write_bus5();
    logic [31:0] rd; int cyc;
    resp_lat = 1;
    io_xfer(1, 16'h0CF8, 2'd2, 32'h8005_FFFC, rd, cyc);
    io_xfer(1, 16'h0CFC, 2'd2, 32'h1122_3344, rd, cyc);
    check("R2 bus5", cap_bus, 8'h05);
    check("R2 devfn max", cap_devfn, 8'hFF);
    check("R2 reg max", cap_reg, 8'hFC);
    check("R5 type1", cap_t1, 1'b1);
    check("R9 write dir", cap_we, 1'b1);
    check("R4 dword wdata", cap_wdata, 32'h1122_3344);
  endtask

  task automatic t_lanes();
    logic [31:0] rd; int cyc;
    resp_lat = 0;
    io_xfer(0, 16'h0CFE, 2'd0, 0, rd, cyc);
    check("R4 byte off2 be", cap_be, 4'b0100);
    check("R4 byte off2 rdata", rd, 32'h0000_00B2);
    io_xfer(1, 16'h0CFE, 2'd1, 32'h0000_BEEF, rd, cyc);
    check("R4 word off2 be", cap_be, 4'b1100);
    check("R4 word off2 wdata", cap_wdata, 32'hBEEF_0000);
    io_xfer(1, 16'h0CFF, 2'd0, 32'h0000_005A, rd, cyc);
    check("R4 byte off3 be", cap_be, 4'b1000);
    check("R4 byte off3 wdata", cap_wdata, 32'h5A00_0000);
    io_xfer(0, 16'h0CFF, 2'd1, 0, rd, cyc);
    check("R4 word off3 be", cap_be, 4'b1000);
    check("R4 word off3 rdata", rd, 32'h0000_00A1);
    io_xfer(0, 16'h0CFC, 2'd1, 0, rd, cyc);
    check("R4 word off0 rdata", rd, 32'h0000_C3D4);
  endtask

  task automatic t_stall();
    logic [31:0] rd; int cyc;
    resp_lat = 10;
    resp_data = 32'h0BAD_F00D;
    io_xfer(0, 16'h0CFC, 2'd2, 0, rd, cyc);
    check("R6 held until ack", (cyc >= 11) ? 32'd1 : 32'd0, 32'd1);
    check("R6 stalled data", rd, 32'h0BAD_F00D);
    resp_data = 32'hA1B2C3D4;
  endtask

  task automatic t_timeout();
    logic [31:0] rd; int cyc; int n0;
    resp_on = 1'b0;
    n0 = req_cnt;
    io_xfer(0, 16'h0CFC, 2'd2, 0, rd, cyc);
    check("R7 timeout read ones", rd, 32'hFFFF_FFFF);
    check("R7 request issued", req_cnt, n0 + 1);
    check("R7 waited window", (cyc >= 64 && cyc < 70) ? 32'd1 : 32'd0, 32'd1);
    io_xfer(1, 16'h0CFC, 2'd2, 32'h1, rd, cyc);
    check("R7 timeout write completes", {31'd0, cfg_req_o}, 32'd0);
    resp_on = 1'b1;
    resp_lat = 0;
    io_xfer(0, 16'h0CFC, 2'd2, 0, rd, cyc);
    check("R7 recovery read", rd, 32'hA1B2_C3D4);
  endtask

  task automatic t_unclaimed();
    logic [31:0] rd; int cyc; int n0;
    n0 = req_cnt;
    io_xfer(0, 16'h0080, 2'd2, 0, rd, cyc);
    check("R8 other address ones", rd, 32'hFFFF_FFFF);
    io_xfer(1, 16'h0CF8, 2'd0, 32'h0000_0000, rd, cyc);
    io_xfer(0, 16'h0CF8, 2'd1, 0, rd, cyc);
    check("R8 narrow addr read ones", rd, 32'hFFFF_FFFF);
    io_xfer(0, 16'h0CF8, 2'd2, 0, rd, cyc);
    check("R8 selector unchanged", rd, 32'h8000_1A0C);
    check("R8 no request", req_cnt, n0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_sel_readback();
    t_disabled();
    t_dword_read_bus0();
    t_dword_write_bus5();
    t_lanes();
    t_stall();
    t_timeout();
    io_xfer_sel_restore();
    t_unclaimed();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic io_xfer_sel_restore();
    logic [31:0] rd; int cyc;
    io_xfer(1, 16'h0CF8, 2'd2, 32'h8000_1A0C, rd, cyc);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule